// File: doc/BRIEF.md
# Full-Bridge Gate Control Logic

This block is the synchronous control core for an H-bridge built from two half-bridges. Each half takes a low-side and a high-side command bit and produces a low-side and a high-side gate enable. Conflicting commands are resolved so that a half can never conduct straight through. The low command always wins. Turn-on edges are held back by a programmable dead time: one setting serves both upper switches and another serves both lower switches. Turn-off edges pass with no added delay.

A disable input and an undervoltage flag each force every gate enable low. When both are clear again, a release sequence runs. Every lower switch receives a fixed-width refresh pulse, and the upper switches stay blocked until an enable window has expired. That window is always longer than the refresh pulse. If a half's high command is tied high, the half acts as a single-input complementary driver, with dead time applied at each edge of its low command.

All command and flag inputs pass through two-flop synchronizers. Dead times, the refresh width and the upper-enable window are given in clock cycles. Reset behaves like a release from disable.

Top module: `hbridge_gate_ctrl`

## Requirements
- R1: While rst_ni is low, all gate outputs are 0. After reset is released with all inputs low, every low gate shows the refresh pulse of R9, beginning 3 cycles after release.
- R2: Raising dis_i forces all four gate outputs to 0 within 3 clock edges, whatever the commands are.
- R3: Raising uv_i has the same effect as R2.
- R4: When a half's low command is 1, its low gate turns on and its high gate stays 0, even if the high command is also 1.
- R5: A half whose low command is 0 and high command is 1 drives only its high gate. A half with both commands 0 drives neither gate.
- R6: A low gate rises 3 + LO_DEAD_CYC cycles after its request appears at the pins and falls 3 cycles after the request goes away.
- R7: A high gate rises 3 + HI_DEAD_CYC cycles after its request appears (once the upper enable is open) and falls 3 cycles after the request goes away.
- R8: With a half's high command held at 1, toggling its low command alone swaps the gates. The outgoing gate falls after 3 cycles, and the incoming gate rises after 3 plus its dead time.
- R9: When disable and undervoltage are both clear again, each low gate is held high for exactly REFRESH_CYC cycles, starting 3 cycles after release. This holds even if its low command drops during that window.
- R10: After a release, no high gate can rise before cycle 4 + UPEN_CYC + HI_DEAD_CYC, counted from release. UPEN_CYC is raised internally to REFRESH_CYC + 1 if it is set lower.
- R11: If a low command is raised during the refresh pulse, its low gate stays high without a gap past the end of the refresh.
- R12: The low and high gates of one half are never both 1 in the same cycle.
- R13: The two halves act independently. Index 0 is half A and index 1 is half B.
- R14: A request that lasts fewer edges than its dead time leaves the gate at 0, and a new request after a gap restarts the count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lo_cmd_i | input | NUM_HALF | Low-side command per half (bit 0 = A, bit 1 = B) |
| hi_cmd_i | input | NUM_HALF | High-side command per half |
| dis_i | input | 1 | Global disable, active high |
| uv_i | input | 1 | Undervoltage flag, active high |
| lo_gate_o | output | NUM_HALF | Low-side gate enable per half |
| hi_gate_o | output | NUM_HALF | High-side gate enable per half |

## Verification
The hardest state to reach from the pins is a low command that rises partway through a refresh pulse. The low gate must then stay high, with no gap, across the refresh's end. The same goes for a high command that is already present when a disable is lifted, which must stay blocked for the full enable window. Each case starts with disable or undervoltage held high. The flag is then cleared on a known falling clock edge. A per-cycle loop changes the low command at a fixed cycle offset from that edge and samples every gate on each later falling edge. This gives the rise and fall cycle of every gate relative to the release.

// File: rtl/hbg_pkg.sv
`timescale 1ns/1ps
package hbg_pkg;

  // counter width able to hold 0..n
  function automatic int cnt_w(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  // upper enable window must outlast the refresh pulse
  function automatic int upen_eff(input int up, input int rf);
    return (up > rf) ? up : rf + 1;
  endfunction

endpackage

// File: rtl/hbg_sync.sv
`timescale 1ns/1ps
module hbg_sync #(
  parameter int             W       = 1,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;

endmodule

// File: rtl/hbg_on_delay.sv
`timescale 1ns/1ps
module hbg_on_delay #(
  parameter int DEAD = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic on_o
);

  localparam int            CW  = hbg_pkg::cnt_w(DEAD);
  localparam logic [CW-1:0] LIM = CW'(DEAD);

  logic [CW-1:0] cnt_q;
  logic          on_q;

  // drop is immediate; rise needs DEAD+1 consecutive edges of request
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      on_q  <= 1'b0;
    end else if (!req_i) begin
      cnt_q <= '0;
      on_q  <= 1'b0;
    end else if (!on_q) begin
      if (cnt_q >= LIM) on_q  <= 1'b1;
      else              cnt_q <= cnt_q + 1'b1;
    end
  end

  assign on_o = on_q;

  a_r6_r7_fast_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !on_o);

  a_r14_needs_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(on_o) |-> $past(req_i));

endmodule

// File: rtl/hbg_release_seq.sv
`timescale 1ns/1ps
module hbg_release_seq #(
  parameter int REFRESH_CYC = 82,
  parameter int UPEN_CYC    = 90
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inhibit_i,
  output logic refresh_o,
  output logic up_en_o
);

  localparam int UPEN_EFF = hbg_pkg::upen_eff(UPEN_CYC, REFRESH_CYC);
  localparam int RW       = hbg_pkg::cnt_w(REFRESH_CYC);
  localparam int UW       = hbg_pkg::cnt_w(UPEN_EFF);
  localparam logic [RW-1:0] R_LAST = RW'(REFRESH_CYC - 1);
  localparam logic [UW-1:0] U_LAST = UW'(UPEN_EFF - 1);

  logic          inh_q;
  logic          rel;
  logic          ref_q, up_q;
  logic [RW-1:0] ref_cnt_q;
  logic [UW-1:0] up_cnt_q;

  // reset value 1: leaving reset counts as a release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) inh_q <= 1'b1;
    else         inh_q <= inhibit_i;
  end

  assign rel = inh_q & ~inhibit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q     <= 1'b0;
      ref_cnt_q <= '0;
    end else if (inhibit_i) begin
      ref_q     <= 1'b0;
      ref_cnt_q <= '0;
    end else if (rel) begin
      ref_q     <= 1'b1;
      ref_cnt_q <= '0;
    end else if (ref_q) begin
      if (ref_cnt_q == R_LAST) ref_q     <= 1'b0;
      else                     ref_cnt_q <= ref_cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_q     <= 1'b0;
      up_cnt_q <= '0;
    end else if (inhibit_i) begin
      up_q     <= 1'b0;
      up_cnt_q <= '0;
    end else if (rel) begin
      up_cnt_q <= '0;
    end else if (!up_q) begin
      if (up_cnt_q == U_LAST) up_q     <= 1'b1;
      else                    up_cnt_q <= up_cnt_q + 1'b1;
    end
  end

  assign refresh_o = ref_q;
  assign up_en_o   = up_q;

  a_r10_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh_o |-> !up_en_o);

  a_r9_refresh_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel |=> refresh_o);

  a_r2_seq_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inhibit_i |=> (!refresh_o && !up_en_o));

endmodule

// File: rtl/hbg_half.sv
`timescale 1ns/1ps
module hbg_half #(
  parameter int LO_DEAD = 3,
  parameter int HI_DEAD = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lo_cmd_i,
  input  logic hi_cmd_i,
  input  logic inhibit_i,
  input  logic up_en_i,
  input  logic refresh_i,
  output logic lo_gate_o,
  output logic hi_gate_o
);

  logic lo_req, hi_req;
  logic lo_on, hi_on;

  // low command wins; upper also needs the post-release enable
  assign lo_req = ~inhibit_i & lo_cmd_i;
  assign hi_req = ~inhibit_i & up_en_i & hi_cmd_i & ~lo_cmd_i;

  hbg_on_delay #(.DEAD(LO_DEAD)) u_lo_dly (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (lo_req),
    .on_o   (lo_on)
  );

  hbg_on_delay #(.DEAD(HI_DEAD)) u_hi_dly (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (hi_req),
    .on_o   (hi_on)
  );

  assign lo_gate_o = lo_on | refresh_i;
  assign hi_gate_o = hi_on;

  a_r12_no_shoot_through: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lo_gate_o && hi_gate_o));

  a_r4_low_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_cmd_i && !inhibit_i) |=> !hi_gate_o);

  a_r10_upper_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !up_en_i |=> !$rose(hi_gate_o));

endmodule

// File: rtl/hbridge_gate_ctrl.sv
`timescale 1ns/1ps
module hbridge_gate_ctrl #(
  parameter int NUM_HALF    = 2,
  parameter int LO_DEAD_CYC = 3,
  parameter int HI_DEAD_CYC = 4,
  parameter int REFRESH_CYC = 82,
  parameter int UPEN_CYC    = 90
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_HALF-1:0] lo_cmd_i,
  input  logic [NUM_HALF-1:0] hi_cmd_i,
  input  logic                dis_i,
  input  logic                uv_i,
  output logic [NUM_HALF-1:0] lo_gate_o,
  output logic [NUM_HALF-1:0] hi_gate_o
);

  localparam int CMD_W = 2 * NUM_HALF;

  logic [CMD_W-1:0]    cmd_s;
  logic [1:0]          flag_s;
  logic [NUM_HALF-1:0] lo_s, hi_s;
  logic                inhibit;
  logic                refresh, up_en;

  hbg_sync #(.W(CMD_W), .RST_VAL('0)) u_cmd_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({hi_cmd_i, lo_cmd_i}),
    .q_o    (cmd_s)
  );

  // flags come out of reset asserted so release sequence follows reset
  hbg_sync #(.W(2), .RST_VAL(2'b11)) u_flag_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({uv_i, dis_i}),
    .q_o    (flag_s)
  );

  assign lo_s    = cmd_s[NUM_HALF-1:0];
  assign hi_s    = cmd_s[CMD_W-1:NUM_HALF];
  assign inhibit = |flag_s;

  hbg_release_seq #(
    .REFRESH_CYC (REFRESH_CYC),
    .UPEN_CYC    (UPEN_CYC)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .inhibit_i (inhibit),
    .refresh_o (refresh),
    .up_en_o   (up_en)
  );

  for (genvar g = 0; g < NUM_HALF; g++) begin : g_half
    hbg_half #(
      .LO_DEAD (LO_DEAD_CYC),
      .HI_DEAD (HI_DEAD_CYC)
    ) u_half (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .lo_cmd_i  (lo_s[g]),
      .hi_cmd_i  (hi_s[g]),
      .inhibit_i (inhibit),
      .up_en_i   (up_en),
      .refresh_i (refresh),
      .lo_gate_o (lo_gate_o[g]),
      .hi_gate_o (hi_gate_o[g])
    );
  end

  a_r2_r3_inhibit_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inhibit |=> (lo_gate_o == '0 && hi_gate_o == '0));

endmodule

// File: tb/hbridge_gate_ctrl_tb_top.sv
`timescale 1ns/1ps
module hbridge_gate_ctrl_tb_top;

  localparam int LD = 3;
  localparam int HD = 5;
  localparam int RF = 20;
  localparam int UP = 26;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] lo_cmd = '0, hi_cmd = '0;
  logic       dis = 1'b0, uv = 1'b0;
  logic [1:0] lo_g, hi_g;

  int checks = 0, errors = 0;
  int rise_lo[2], fall_lo[2], rise_hi[2], fall_hi[2];
  int overlap;
  logic [1:0] prv_lo, prv_hi;
  bit done = 0;

  always #2.5 clk = ~clk;

  hbridge_gate_ctrl #(
    .NUM_HALF(2), .LO_DEAD_CYC(LD), .HI_DEAD_CYC(HD),
    .REFRESH_CYC(RF), .UPEN_CYC(UP)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .lo_cmd_i(lo_cmd), .hi_cmd_i(hi_cmd),
    .dis_i(dis), .uv_i(uv), .lo_gate_o(lo_g), .hi_gate_o(hi_g)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clr_rec();
    for (int h = 0; h < 2; h++) begin
      rise_lo[h] = 0; fall_lo[h] = 0; rise_hi[h] = 0; fall_hi[h] = 0;
    end
    overlap = 0;
    prv_lo = lo_g; prv_hi = hi_g;
  endtask

  task automatic sample(input int k);
    for (int h = 0; h < 2; h++) begin
      if (!prv_lo[h] && lo_g[h] && rise_lo[h] == 0) rise_lo[h] = k;
      if (prv_lo[h] && !lo_g[h] && fall_lo[h] == 0) fall_lo[h] = k;
      if (!prv_hi[h] && hi_g[h] && rise_hi[h] == 0) rise_hi[h] = k;
      if (prv_hi[h] && !hi_g[h] && fall_hi[h] == 0) fall_hi[h] = k;
      if (lo_g[h] && hi_g[h]) overlap++;
    end
    prv_lo = lo_g; prv_hi = hi_g;
  endtask

  // caller has just changed inputs on a falling edge
  task automatic watch(input int n);
    clr_rec();
    for (int k = 1; k <= n; k++) begin
      @(posedge clk); @(negedge clk);
      sample(k);
    end
    chk("R12 overlap cycles", overlap, 0);
  endtask

  // release a flag at cycle 0, optionally change low commands at cycle k_act
  task automatic release_run(input bit use_uv, input int k_act,
                             input logic [1:0] lo_new, input int n);
    @(negedge clk);
    if (use_uv) uv = 1'b0; else dis = 1'b0;
    clr_rec();
    for (int k = 1; k <= n; k++) begin
      @(posedge clk); @(negedge clk);
      sample(k);
      if (k == k_act) lo_cmd = lo_new;
    end
    chk("R12 overlap cycles", overlap, 0);
  endtask

  task automatic set_cmd(input logic [1:0] lo, input logic [1:0] hi);
    @(negedge clk);
    lo_cmd = lo; hi_cmd = hi;
  endtask

  task automatic t_reset();
    lo_cmd = 2'b11; hi_cmd = 2'b11;
    repeat (4) @(negedge clk);
    chk("R1 lo in reset", int'(lo_g), 0);
    chk("R1 hi in reset", int'(hi_g), 0);
    lo_cmd = '0; hi_cmd = '0;
    rst_ni = 1'b1;
    watch(RF + 10);
    chk("R1 refresh A rise", rise_lo[0], 3);
    chk("R1 refresh B rise", rise_lo[1], 3);
    chk("R9 refresh A fall", fall_lo[0], 3 + RF);
    chk("R1 no hi after reset", rise_hi[0] + rise_hi[1], 0);
    repeat (UP) @(negedge clk);
  endtask

  task automatic t_low_priority();
    set_cmd(2'b01, 2'b01);
    watch(15);
    chk("R4 lo on rise", rise_lo[0], 3 + LD);
    chk("R4 hi stays off", rise_hi[0], 0);
    chk("R4 final hi", int'(hi_g[0]), 0);
    set_cmd(2'b00, 2'b01);
    watch(15);
    chk("R5 lo off", fall_lo[0], 3);
    chk("R5 hi only on", rise_hi[0], 3 + HD);
    set_cmd(2'b00, 2'b00);
    watch(10);
    chk("R7 hi off", fall_hi[0], 3);
    chk("R5 both off", int'({lo_g, hi_g}), 0);
  endtask

  task automatic t_lo_delay();
    set_cmd(2'b01, 2'b00);
    watch(12);
    chk("R6 lo on delay", rise_lo[0], 3 + LD);
    set_cmd(2'b00, 2'b00);
    watch(8);
    chk("R6 lo off delay", fall_lo[0], 3);
  endtask

  task automatic t_hi_delay();
    set_cmd(2'b00, 2'b01);
    watch(14);
    chk("R7 hi on delay", rise_hi[0], 3 + HD);
    chk("R5 lo stays off", rise_lo[0], 0);
    set_cmd(2'b00, 2'b00);
    watch(8);
    chk("R7 hi off delay", fall_hi[0], 3);
  endtask

  task automatic t_compl();
    set_cmd(2'b11, 2'b11);
    watch(15);
    set_cmd(2'b10, 2'b11);
    watch(15);
    chk("R8 lo falls", fall_lo[0], 3);
    chk("R8 hi rises", rise_hi[0], 3 + HD);
    chk("R13 B untouched", rise_lo[1] + fall_lo[1] + rise_hi[1], 0);
    set_cmd(2'b11, 2'b11);
    watch(15);
    chk("R8 hi falls", fall_hi[0], 3);
    chk("R8 lo rises", rise_lo[0], 3 + LD);
    set_cmd(2'b00, 2'b00);
    watch(10);
  endtask

  task automatic t_indep();
    set_cmd(2'b01, 2'b10);
    watch(15);
    chk("R13 A lo", rise_lo[0], 3 + LD);
    chk("R13 B hi", rise_hi[1], 3 + HD);
    chk("R13 A hi off", rise_hi[0], 0);
    chk("R13 B lo off", rise_lo[1], 0);
    set_cmd(2'b00, 2'b00);
    watch(10);
  endtask

  task automatic t_short();
    int seen;
    seen = 0;
    for (int k = 0; k < 25; k++) begin
      @(negedge clk);
      if (lo_g[0]) seen++;
      lo_cmd[0] = (k < LD) || (k > LD && k <= 2 * LD);
    end
    chk("R14 short pulses ignored", seen, 0);
    seen = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (lo_g[0]) seen++;
      lo_cmd[0] = (k <= LD);
    end
    chk("R14 just long enough", seen, 1);
  endtask

  task automatic t_disable();
    set_cmd(2'b01, 2'b10);
    watch(15);
    @(negedge clk); dis = 1'b1;
    watch(10);
    chk("R2 A lo off", fall_lo[0], 3);
    chk("R2 B hi off", fall_hi[1], 3);
    chk("R2 all off", int'({lo_g, hi_g}), 0);
    release_run(1'b0, -1, 2'b01, UP + HD + 10);
    chk("R9 A lo at release", rise_lo[0], 3);
    chk("R9 A lo held", fall_lo[0], 0);
    chk("R9 B refresh rise", rise_lo[1], 3);
    chk("R9 B refresh fall", fall_lo[1], 3 + RF);
    chk("R10 B hi rise", rise_hi[1], 4 + UP + HD);
    chk("R4 A hi off", rise_hi[0], 0);
    set_cmd(2'b00, 2'b00);
    watch(10);
  endtask

  task automatic t_reassert();
    @(negedge clk); dis = 1'b1;
    watch(6);
    release_run(1'b0, 5, 2'b01, RF + 12);
    chk("R11 lo rise", rise_lo[0], 3);
    chk("R11 no gap", fall_lo[0], 0);
    chk("R11 lo still on", int'(lo_g[0]), 1);
    chk("R9 B refresh width", fall_lo[1] - rise_lo[1], RF);
    set_cmd(2'b00, 2'b00);
    watch(10);
  endtask

  task automatic t_uv();
    set_cmd(2'b01, 2'b00);
    watch(12);
    @(negedge clk); uv = 1'b1;
    watch(8);
    chk("R3 lo off", fall_lo[0], 3);
    release_run(1'b1, 3, 2'b00, RF + 12);
    chk("R9 A rise", rise_lo[0], 3);
    chk("R9 A fixed width", fall_lo[0], 3 + RF);
    chk("R9 B fixed width", fall_lo[1], 3 + RF);
    repeat (UP) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_low_priority();
    t_lo_delay();
    t_hi_delay();
    t_compl();
    t_indep();
    t_short();
    t_disable();
    t_reassert();
    t_uv();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule